// File: doc/BRIEF.md
# Serial Peripheral Controller with Status Flags

This block is a byte-wide serial peripheral port that sits on a simple CPU register bus. The bus sees two registers. The data register starts a transfer when written and returns the last received byte when read. The status register reports transfer completion and write collision, and it holds a double-speed control bit. The remaining configuration comes from static control inputs: master or slave role, clock polarity, clock phase, bit order, clock ratio, interrupt enable, and whether the slave-select pin acts as an input.

In master mode the block drives the serial clock from a divider of the system clock and shifts one byte out while it shifts one byte in. In slave mode it follows an external serial clock, which is synchronised into the system clock domain, while its select input is low. The two flags clear in one of two ways. The first is a status read that saw a flag set, followed by any access to the data register. The second is an interrupt acknowledge, which clears only the completion flag.

Top module: `spi_port`

## Requirements
- R1: A data-register write while idle starts an 8-bit transfer. When the transfer ends, status bit 7 (completion) is set and a data-register read returns the received byte.
- R2: In master mode the serial clock period is 4, 16, 64 or 128 system clocks for `cfg_rate` = 0, 1, 2 or 3. Setting the double-speed bit halves the period, so the shortest period is 2 clocks.
- R3: The serial clock rests at `cfg_cpol`. With `cfg_cpha`=0 a bit is sampled on the leading edge, and with `cfg_cpha`=1 on the trailing edge. `sdo` presents bit 7 first, or bit 0 first when `cfg_lsb_first`=1, as soon as the byte is loaded.
- R4: The status register (`bus_sel`=0) reads as {completion, collision, 5'b0, double-speed}. A status write stores `bus_wdata[0]` as the double-speed bit. After reset the status register reads 0x00.
- R5: A data-register write during a transfer sets status bit 6 (collision). It neither alters the byte being shifted nor starts another transfer.
- R6: A flag clears only on a data-register access (`bus_sel`=1, read or write) that follows a status read which saw that flag set. Completion also clears if the status read saw only the collision flag set. A data access with no such prior status read leaves both flags as they are.
- R7: `irq` equals completion AND `cfg_irq_en`. A one-cycle `irq_ack` clears the completion flag and leaves the collision flag untouched.
- R8: In master mode with `cfg_ss_in`=1, a low `ss_n` sets the completion flag within 4 clocks. With `cfg_ss_in`=0, `ss_n` has no effect in master mode.
- R9: In slave mode, while `ss_n` is low, the block shifts a byte on `sck_in` transitions. This works for serial clock periods of 8 system clocks or more. The block drives the loaded byte on `sdo`, then sets completion and buffers the received byte.
- R10: When a set event (transfer end or select fault) and a clear event fall in the same cycle, the completion flag stays set.
- R11: A data-register read during a transfer returns the previously received byte, not the partial shift contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register select: 0 status, 1 data |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, clears completion |
| cfg_master | input | 1 | 1 master, 0 slave |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_ss_in | input | 1 | Treat `ss_n` as a fault input in master mode |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sample-edge select |
| cfg_lsb_first | input | 1 | Shift bit 0 first |
| cfg_rate | input | 2 | Clock ratio select |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_in | input | 1 | Serial clock received in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Slave select, active low |

## Verification
The embedded properties watch the following on every cycle:
- the flag update rules: set on transfer end, select fault or busy write; acknowledge clears completion; a set event beats a clear event; an unarmed access keeps the collision flag;
- that the status reserved bits read zero;
- that a transfer is only ever loaded while idle;
- that the master clock rests at its polarity level;
- that divider ticks are spaced apart.

Only the directed scenarios can show the following:
- the end-to-end byte values in loopback and slave operation;
- the measured clock period for each ratio;
- the bit order and phase behaviour on the wire;
- the exact status-read-then-data-access clearing sequence;
- that a colliding write leaves the shifted byte intact.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BYTE_W = 8;
  localparam int EDGES = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam int CNT_W = 7;
  localparam int ST_DONE = 7;
  localparam int ST_COLL = 6;
  localparam int ST_DBL = 0;
  localparam logic REG_STATUS = 1'b0;
  localparam logic REG_DATA = 1'b1;

  typedef logic [BYTE_W-1:0] byte_t;

  // half serial-clock period in system clocks
  function automatic logic [CNT_W-1:0] half_period(input logic [1:0] rate, input logic dbl);
    logic [CNT_W-1:0] h;
    case (rate)
      2'd0:    h = CNT_W'(2);
      2'd1:    h = CNT_W'(8);
      2'd2:    h = CNT_W'(32);
      default: h = CNT_W'(64);
    endcase
    return dbl ? (h >> 1) : h;
  endfunction
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], din};
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen
  import spi_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  input  logic       dbl,
  output logic       tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, half;
  logic wrap;

  always_comb begin
    half  = half_period(rate, dbl);
    wrap  = run && (cnt_q == half - CNT_W'(1));
    cnt_d = (!run || wrap) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || $past(half) == CNT_W'(1)));
endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift
  import spi_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  master,
  input  logic  cpol,
  input  logic  cpha,
  input  logic  lsb_first,
  input  logic  tick,
  input  logic  load,
  input  byte_t load_data,
  input  logic  sck_s,
  input  logic  sdi_raw,
  input  logic  sdi_s,
  input  logic  ss_low,
  output logic  sck_out,
  output logic  sdo,
  output logic  busy,
  output logic  done,
  output byte_t rx_byte
);
  logic              active_q, active_d, phase_q, phase_d, sck_prev_q, done_q;
  logic [EDGE_W-1:0] ecnt_q, ecnt_d;
  byte_t             tx_q, tx_d, rx_q, rx_d;
  logic              edge_ev, lead, sample_ev, shift_ev, last_ev, sdi_bit;

  always_comb begin
    edge_ev   = master ? (active_q && tick)
                       : (ss_low && (sck_s != sck_prev_q));
    lead      = !ecnt_q[0];
    sample_ev = edge_ev && (lead ^ cpha);
    shift_ev  = edge_ev && !(lead ^ cpha) && !(cpha && ecnt_q == '0);
    last_ev   = edge_ev && (ecnt_q == EDGE_W'(EDGES - 1));
    sdi_bit   = master ? sdi_raw : sdi_s;

    tx_d = tx_q; rx_d = rx_q; ecnt_d = ecnt_q;
    active_d = active_q; phase_d = phase_q;
    if (load) begin
      tx_d     = load_data;
      ecnt_d   = '0;
      active_d = master;
      phase_d  = 1'b0;
    end else begin
      if (shift_ev)
        tx_d = lsb_first ? {1'b0, tx_q[BYTE_W-1:1]} : {tx_q[BYTE_W-2:0], 1'b0};
      if (sample_ev)
        rx_d = lsb_first ? {sdi_bit, rx_q[BYTE_W-1:1]} : {rx_q[BYTE_W-2:0], sdi_bit};
      if (edge_ev) begin
        ecnt_d = last_ev ? '0 : ecnt_q + EDGE_W'(1);
        if (master) phase_d = !phase_q;
      end
      if (last_ev) active_d = 1'b0;
      if (!master && !ss_low) ecnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0; phase_q <= 1'b0; sck_prev_q <= 1'b0; done_q <= 1'b0;
      ecnt_q <= '0; tx_q <= '0; rx_q <= '0;
    end else begin
      active_q <= active_d; phase_q <= phase_d; sck_prev_q <= sck_s; done_q <= last_ev;
      ecnt_q <= ecnt_d; tx_q <= tx_d; rx_q <= rx_d;
    end
  end

  assign busy    = master ? active_q : (ecnt_q != '0);
  assign sdo     = lsb_first ? tx_q[0] : tx_q[BYTE_W-1];
  assign sck_out = master ? (cpol ^ phase_q) : cpol;
  assign done    = done_q;
  assign rx_byte = rx_q;

  assert_load_only_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  assert_idle_clock_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy) |-> (sck_out == cpol));
endmodule

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bus_sel,
  input  logic  bus_rd,
  input  logic  bus_wr,
  input  byte_t bus_wdata,
  output byte_t bus_rdata,
  input  logic  irq_ack,
  input  logic  irq_en,
  input  logic  busy,
  input  logic  done,
  input  logic  ss_fault,
  input  byte_t rx_byte,
  output logic  irq,
  output logic  load,
  output logic  dbl
);
  logic  cmp_q, cmp_d, coll_q, coll_d, dbl_q, dbl_d;
  logic  arm_c_q, arm_c_d, arm_w_q, arm_w_d;
  logic  st_rd, st_wr, dat_acc, dat_wr, set_c, clr_c, set_w, clr_w;
  byte_t rxbuf_q, status;

  always_comb begin
    st_rd   = bus_rd && (bus_sel == REG_STATUS);
    st_wr   = bus_wr && (bus_sel == REG_STATUS);
    dat_acc = (bus_rd || bus_wr) && (bus_sel == REG_DATA);
    dat_wr  = bus_wr && (bus_sel == REG_DATA);

    set_c = done || ss_fault;
    clr_c = (dat_acc && arm_c_q) || irq_ack;
    set_w = dat_wr && busy;
    clr_w = dat_acc && arm_w_q;

    cmp_d   = set_c ? 1'b1 : (clr_c ? 1'b0 : cmp_q);
    coll_d  = set_w ? 1'b1 : (clr_w ? 1'b0 : coll_q);
    arm_c_d = st_rd ? (cmp_q || coll_q) : (dat_acc ? 1'b0 : arm_c_q);
    arm_w_d = st_rd ? coll_q : (dat_acc ? 1'b0 : arm_w_q);
    dbl_d   = st_wr ? bus_wdata[0] : dbl_q;

    status          = '0;
    status[ST_DONE] = cmp_q;
    status[ST_COLL] = coll_q;
    status[ST_DBL]  = dbl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0; coll_q <= 1'b0; dbl_q <= 1'b0; arm_c_q <= 1'b0; arm_w_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d; coll_q <= coll_d; dbl_q <= dbl_d; arm_c_q <= arm_c_d; arm_w_q <= arm_w_d;
    end
  end

  // receive buffer: no reset, contents undefined until the first transfer
  always_ff @(posedge clk) begin
    if (done) rxbuf_q <= rx_byte;
  end

  assign bus_rdata = (bus_sel == REG_DATA) ? rxbuf_q : status;
  assign irq       = cmp_q && irq_en;
  assign load      = dat_wr && !busy;
  assign dbl       = dbl_q;

  assert_done_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmp_q);
  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == REG_STATUS) |-> (bus_rdata[ST_COLL-1:ST_DBL+1] == '0));
  assert_busy_write_collides_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == REG_DATA && busy) |=> coll_q);
  assert_unarmed_keeps_coll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_acc && !arm_w_q && coll_q) |=> coll_q);
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !done && !ss_fault) |=> !cmp_q);
  assert_select_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ss_fault |=> cmp_q);
  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((done || ss_fault) && irq_ack) |=> cmp_q);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       irq_ack,
  input  logic       cfg_master,
  input  logic       cfg_irq_en,
  input  logic       cfg_ss_in,
  input  logic       cfg_cpol,
  input  logic       cfg_cpha,
  input  logic       cfg_lsb_first,
  input  logic [1:0] cfg_rate,
  output logic       sck_out,
  input  logic       sck_in,
  output logic       sdo,
  input  logic       sdi,
  input  logic       ss_n
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_s, tick, load, busy, done, dbl, ss_fault;
  logic [2:0] pins_s;
  byte_t      rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  spi_port_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .din({ss_n, sdi, sck_in}), .dout(pins_s));

  assign ss_fault = cfg_master && cfg_ss_in && !pins_s[2];

  spi_port_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_n_s), .run(busy && cfg_master), .rate(cfg_rate),
    .dbl(dbl), .tick(tick));

  spi_port_shift u_shift (
    .clk(clk), .rst_n(rst_n_s), .master(cfg_master), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .lsb_first(cfg_lsb_first), .tick(tick), .load(load), .load_data(bus_wdata),
    .sck_s(pins_s[0]), .sdi_raw(sdi), .sdi_s(pins_s[1]), .ss_low(!pins_s[2]),
    .sck_out(sck_out), .sdo(sdo), .busy(busy), .done(done), .rx_byte(rx_byte));

  spi_port_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq_en(cfg_irq_en),
    .busy(busy), .done(done), .ss_fault(ss_fault), .rx_byte(rx_byte),
    .irq(irq), .load(load), .dbl(dbl));
endmodule

// File: tb/sim_spi_port.sv
`timescale 1ns/1ps
module sim_spi_port;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_rd, bus_wr, irq, irq_ack;
  logic [7:0] bus_wdata, bus_rdata;
  logic cfg_master, cfg_irq_en, cfg_ss_in, cfg_cpol, cfg_cpha, cfg_lsb_first;
  logic [1:0] cfg_rate;
  logic sck_out, sck_in, sdo, sdi, ss_n, loop_en, tb_sdi;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_rise = -1;
  int period = 0;
  int rises = 0;
  logic sck_prev = 1'b0;

  always #2 clk = ~clk;

  assign sdi = loop_en ? sdo : tb_sdi;

  spi_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .irq_ack(irq_ack),
    .cfg_master(cfg_master), .cfg_irq_en(cfg_irq_en), .cfg_ss_in(cfg_ss_in),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_rate(cfg_rate), .sck_out(sck_out), .sck_in(sck_in), .sdo(sdo), .sdi(sdi),
    .ss_n(ss_n));

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sck_out && !sck_prev) begin
      if (last_rise >= 0) period = cyc - last_rise;
      last_rise = cyc;
      rises = rises + 1;
    end
    sck_prev = sck_out;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_done(output logic [7:0] st);
    st = 8'h00;
    for (int n = 0; n < 3000 && !st[7]; n++) bus_read(1'b0, st);
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] rx, output logic [7:0] st);
    bus_write(1'b1, d);
    wait_done(st);
    bus_read(1'b1, rx);
  endtask

  task automatic t_reset;
    logic [7:0] st;
    bus_read(1'b0, st);
    chk("R4 reset status", st, 8'h00);
    chk("R7 reset irq", irq, 1'b0);
    chk("R3 reset clock level", sck_out, 1'b0);
  endtask

  task automatic t_master_basic;
    logic [7:0] st, rx;
    last_rise = -1;
    xfer(8'hA5, rx, st);
    chk("R1 completion status", st, 8'h80);
    chk("R1 received byte", rx, 8'hA5);
    chk("R2 period ratio 4", period, 4);
    bus_read(1'b0, st);
    chk("R6 cleared after sequence", st, 8'h00);
  endtask

  task automatic t_rates;
    logic [7:0] st, rx;
    cfg_rate = 2'd1; last_rise = -1;
    xfer(8'h3E, rx, st);
    chk("R2 period ratio 16", period, 16);
    chk("R1 byte at ratio 16", rx, 8'h3E);
    bus_write(1'b0, 8'hFF);
    bus_read(1'b0, st);
    chk("R4 double-speed readback", st, 8'h01);
    cfg_rate = 2'd0; last_rise = -1;
    xfer(8'hC7, rx, st);
    chk("R2 period ratio 2", period, 2);
    chk("R1 byte at ratio 2", rx, 8'hC7);
    cfg_rate = 2'd3; last_rise = -1;
    xfer(8'h18, rx, st);
    chk("R2 period ratio 64", period, 64);
    bus_write(1'b0, 8'h00);
    cfg_rate = 2'd0;
  endtask

  task automatic t_modes;
    logic [7:0] st, rx;
    cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_lsb_first = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 idle high", sck_out, 1'b1);
    bus_write(1'b1, 8'h1D);
    chk("R3 first bit lsb", sdo, 1'b1);
    wait_done(st);
    bus_read(1'b1, rx);
    chk("R3 loopback cpol1 cpha1 lsb", rx, 8'h1D);
    chk("R3 idle high after", sck_out, 1'b1);
    cfg_cpol = 1'b0; cfg_lsb_first = 1'b0;
    bus_write(1'b1, 8'h96);
    chk("R3 first bit msb", sdo, 1'b1);
    wait_done(st);
    bus_read(1'b1, rx);
    chk("R3 loopback cpha1 msb", rx, 8'h96);
    cfg_cpha = 1'b0;
  endtask

  task automatic t_collision;
    logic [7:0] st, rx;
    int r0;
    xfer(8'h69, rx, st);
    cfg_rate = 2'd2;
    bus_write(1'b1, 8'h3C);
    repeat (20) @(negedge clk);
    bus_read(1'b1, rx);
    chk("R11 buffer during transfer", rx, 8'h69);
    bus_write(1'b1, 8'hFF);
    bus_read(1'b0, st);
    chk("R5 collision flag", st, 8'h40);
    wait_done(st);
    chk("R5 both flags", st, 8'hC0);
    bus_read(1'b1, rx);
    chk("R5 shifted byte intact", rx, 8'h3C);
    bus_read(1'b0, st);
    chk("R6 both cleared", st, 8'h00);
    r0 = rises;
    repeat (150) @(negedge clk);
    chk("R5 no second transfer", rises, r0);
    cfg_rate = 2'd0;
  endtask

  task automatic t_clear_seq;
    logic [7:0] st, rx;
    bus_write(1'b1, 8'h11);
    repeat (80) @(negedge clk);
    bus_read(1'b1, rx);
    chk("R1 byte without polling", rx, 8'h11);
    bus_read(1'b0, st);
    chk("R6 unarmed access keeps flag", st, 8'h80);
    bus_read(1'b1, rx);
    bus_read(1'b0, st);
    chk("R6 armed access clears", st, 8'h00);
    bus_write(1'b1, 8'h22);
    repeat (3) @(negedge clk);
    bus_write(1'b1, 8'h33);
    repeat (80) @(negedge clk);
    bus_read(1'b1, rx);
    chk("R5 collision did not disturb", rx, 8'h22);
    bus_read(1'b0, st);
    chk("R6 unarmed keeps both", st, 8'hC0);
    bus_read(1'b1, rx);
    bus_read(1'b0, st);
    chk("R6 armed clears both", st, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] st, rx;
    cfg_irq_en = 1'b1;
    bus_write(1'b1, 8'h5E);
    repeat (3) @(negedge clk);
    bus_write(1'b1, 8'h00);
    repeat (80) @(negedge clk);
    chk("R7 irq raised", irq, 1'b1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R7 irq dropped", irq, 1'b0);
    bus_read(1'b0, st);
    chk("R7 ack keeps collision", st, 8'h40);
    bus_read(1'b1, rx);
    chk("R1 byte with irq", rx, 8'h5E);
    bus_read(1'b0, st);
    chk("R6 cleared after irq test", st, 8'h00);
    cfg_irq_en = 1'b0;
  endtask

  task automatic t_ss_fault;
    logic [7:0] st;
    cfg_ss_in = 1'b0; ss_n = 1'b0;
    repeat (10) @(negedge clk);
    bus_read(1'b0, st);
    chk("R8 select ignored when output", st, 8'h00);
    cfg_ss_in = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(1'b0, st);
    chk("R8 select fault sets flag", st, 8'h80);
    irq_ack = 1'b1;
    repeat (6) @(negedge clk);
    bus_read(1'b0, st);
    chk("R10 set wins over ack", st, 8'h80);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
    bus_read(1'b0, st);
    chk("R7 ack clears after fault ends", st, 8'h00);
    irq_ack = 1'b0; cfg_ss_in = 1'b0;
  endtask

  task automatic t_slave;
    logic [7:0] st, rx, cap;
    logic [7:0] din;
    din = 8'h5A; cap = 8'h00;
    cfg_master = 1'b0; loop_en = 1'b0; sck_in = 1'b0; tb_sdi = 1'b0;
    repeat (4) @(negedge clk);
    bus_write(1'b1, 8'hC3);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      tb_sdi = din[i];
      repeat (6) @(negedge clk);
      cap[i] = sdo;
      sck_in = 1'b1;
      repeat (6) @(negedge clk);
      sck_in = 1'b0;
    end
    repeat (10) @(negedge clk);
    ss_n = 1'b1;
    wait_done(st);
    chk("R9 slave completion", st[7], 1'b1);
    bus_read(1'b1, rx);
    chk("R9 slave received", rx, 8'h5A);
    chk("R9 slave transmitted", cap, 8'hC3);
    cfg_master = 1'b1; loop_en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    irq_ack = 1'b0; cfg_master = 1'b1; cfg_irq_en = 1'b0; cfg_ss_in = 1'b0;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_rate = 2'd0;
    sck_in = 1'b0; ss_n = 1'b1; loop_en = 1'b1; tb_sdi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_master_basic();
    t_rates();
    t_modes();
    t_collision();
    t_clear_seq();
    t_irq();
    t_ss_fault();
    t_slave();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule